// File: doc/BRIEF.md
# Calendar Clock with BCD Year

This block keeps wall-clock time for a chip. It stores the time as one packed word of binary calendar fields: second, minute, hour, day of week, day of month and month. A separate 16-bit word holds the year as four BCD digits, with the century in the upper byte. Each pulse on the one-second tick input advances the packed word by one second. The carry runs up through the fields and follows the real month lengths, including leap-year February. When December rolls over into January, the BCD year increments.

Software sets the time through two load offsets. It arms an alarm through two match offsets and starts or stops counting with a run bit in the control word. A sticky alarm status bit sets when the packed word and the year both become equal to their match values. The `alarm` pin follows this bit until software clears it through a clear offset. Register access uses plain write strobes and a combinational read port.

Top module: `cal_clock`

## Requirements
- R1: After a synchronous reset the packed word reads 0x0212_0000 (00:00:00, weekday 1, day 1, month 1), the year reads 0x2000, and the control word, the status word and `alarm` are all 0.
- R2: A write to offset 0x08 replaces the packed word, and a write to offset 0x38 replaces the year. Either write takes effect on the next clock, with or without the run bit, and wins over a tick in the same cycle.
- R3: A tick advances the time only while control bit 26 (offset 0x0C) is 1. With that bit at 0, ticks leave the packed word and the year unchanged.
- R4: Field layout is second [5:0] (0..59), minute [11:6] (0..59), hour [16:12] (0..23), weekday [19:17], day [24:20] and month [28:25]. Seconds wrap 59→0 and carry into minutes, minutes wrap 59→0 and carry into hours, and hours wrap 23→0 and carry into the day.
- R5: Every day carry advances the weekday by one, and weekday 7 wraps to 1.
- R6: The day wraps to 1 and the month advances after day 30 in months 4, 6, 9 and 11, after day 31 in the other months except February, and after day 28 or 29 in February.
- R7: February has 29 days when the year is a multiple of 4, except that a year that is a multiple of 100 has 29 days only when it is also a multiple of 400.
- R8: When month 12 wraps to month 1, the BCD year (offset 0x30, low byte = year in century, high byte = century) increments with decimal carry across all four digits, and 9999 wraps to 0000.
- R9: When the packed word and the year newly become equal to the match words (offsets 0x04 and 0x34), status bit 0 (offset 0x14) and `alarm` become 1 on the following clock. They stay 1 until cleared.
- R10: Writing a 1 in bit 0 to offset 0x1C clears the status bit. The bit does not set again while the same equality persists.
- R11: The weekday field is always part of the comparison. A match word that differs from the time only in weekday never raises the alarm.
- R12: The read port returns the packed word at 0x00 and 0x08, the time match at 0x04, the control word at 0x0C, the status at 0x14, the year at 0x30 and 0x38, the year match at 0x34, and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| alarm | output | 1 | Sticky alarm status bit |

## Verification
The properties assume that `sec_tick` is a single-cycle pulse. They also assume that loaded calendar fields are in range, because the rising-alarm and hold checks only mean something when the clock is counting from a valid date. The stimulus only loads real calendar dates through the load offsets and pulses the tick for exactly one cycle, with idle cycles between pulses. Sweeps cover the last two days of every month in a common year and a leap year, February in the century years, and a two-hour run of every second across midnight, so each carry path is taken from valid states only.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam int YEAR_W = 16;
    localparam int RUN_BIT = 26;

    localparam logic [ADDR_W-1:0] OFS_TIME   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_TMATCH = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_TLOAD  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_YEAR   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_YMATCH = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_YLOAD  = 8'h38;

    typedef struct packed {
        logic [2:0] pad;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    localparam cal_time_t TIME_RESET = '{pad: 3'd0, mon: 4'd1, mday: 5'd1,
                                         wday: 3'd1, hour: 5'd0, min: 6'd0, sec: 6'd0};

    // two BCD digits divisible by 4: 10*h + l == 2*h + l (mod 4)
    function automatic logic bcd_pair_div4(input logic [7:0] b);
        logic [4:0] s;
        s = {b[7:4], 1'b0} + {1'b0, b[3:0]};
        return (s[1:0] == 2'd0);
    endfunction

    function automatic logic year_is_leap(input logic [YEAR_W-1:0] y);
        if (y[7:0] != 8'h00)
            return bcd_pair_div4(y[7:0]);
        return bcd_pair_div4(y[15:8]);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
        case (mon)
            4'd2:                    return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_time_counter.sv
module cal_time_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      advance,
    input  logic      load_en,
    input  cal_time_t load_val,
    input  logic      leap,
    output cal_time_t time_q,
    output logic      year_carry
);

    cal_time_t nxt;
    logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;

    always_comb begin
        sec_wrap  = (time_q.sec  >= 6'd59);
        min_wrap  = (time_q.min  >= 6'd59);
        hour_wrap = (time_q.hour >= 5'd23);
        day_wrap  = (time_q.mday >= month_len(time_q.mon, leap));
        mon_wrap  = (time_q.mon  >= 4'd12);
        year_carry = advance && !load_en && sec_wrap && min_wrap && hour_wrap
                     && day_wrap && mon_wrap;

        nxt = time_q;
        if (!sec_wrap) begin
            nxt.sec = time_q.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (!min_wrap) begin
                nxt.min = time_q.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (!hour_wrap) begin
                    nxt.hour = time_q.hour + 5'd1;
                end else begin
                    nxt.hour = 5'd0;
                    nxt.wday = (time_q.wday >= 3'd7) ? 3'd1 : time_q.wday + 3'd1;
                    if (!day_wrap) begin
                        nxt.mday = time_q.mday + 5'd1;
                    end else begin
                        nxt.mday = 5'd1;
                        nxt.mon  = mon_wrap ? 4'd1 : time_q.mon + 4'd1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            time_q <= TIME_RESET;
        else if (load_en)
            time_q <= load_val;
        else if (advance)
            time_q <= nxt;
    end

endmodule

// File: rtl/cal_bcd_counter.sv
module cal_bcd_counter #(
    parameter int DIGITS = 4,
    parameter logic [4*DIGITS-1:0] RESET_VAL = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                inc,
    input  logic                load_en,
    input  logic [4*DIGITS-1:0] load_val,
    output logic [4*DIGITS-1:0] value_q
);

    localparam int VAL_W = 4 * DIGITS;

    logic [DIGITS:0]    carry;
    logic [VAL_W-1:0]   nxt;

    assign carry[0] = inc;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] d;
        logic       at_nine;
        assign d       = value_q[4*i +: 4];
        assign at_nine = (d >= 4'd9);
        assign nxt[4*i +: 4] = carry[i] ? (at_nine ? 4'd0 : d + 4'd1) : d;
        assign carry[i+1]    = carry[i] && at_nine;
    end

    always_ff @(posedge clk) begin
        if (rst)
            value_q <= RESET_VAL;
        else if (load_en)
            value_q <= load_val;
        else
            value_q <= nxt;
    end

endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cal_time_t         time_now,
    input  logic [YEAR_W-1:0] year_now,
    input  cal_time_t         time_match,
    input  logic [YEAR_W-1:0] year_match,
    input  logic              clear,
    output logic              status_q
);

    logic eq, eq_q;

    assign eq = (time_now == time_match) && (year_now == year_match);

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_q     <= 1'b0;
            status_q <= 1'b0;
        end else begin
            eq_q <= eq;
            if (eq && !eq_q)
                status_q <= 1'b1;
            else if (clear)
                status_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
#(
    parameter logic [YEAR_W-1:0] RESET_YEAR = 16'h2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              alarm
);

    localparam int YEAR_DIGITS = YEAR_W / 4;

    logic              run_q;
    cal_time_t         time_q, match_time_q;
    logic [YEAR_W-1:0] year_q, match_year_q;
    logic              ld_time, ld_year, wr_ctrl, wr_tmatch, wr_ymatch, wr_clr;
    logic              advance, year_carry, leap;

    assign ld_time   = wr_en && (wr_addr == OFS_TLOAD);
    assign ld_year   = wr_en && (wr_addr == OFS_YLOAD);
    assign wr_ctrl   = wr_en && (wr_addr == OFS_CTRL);
    assign wr_tmatch = wr_en && (wr_addr == OFS_TMATCH);
    assign wr_ymatch = wr_en && (wr_addr == OFS_YMATCH);
    assign wr_clr    = wr_en && (wr_addr == OFS_CLR) && wr_data[0];

    assign advance = sec_tick && run_q;
    assign leap    = year_is_leap(year_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q        <= 1'b0;
            match_time_q <= '0;
            match_year_q <= '0;
        end else begin
            if (wr_ctrl)   run_q        <= wr_data[RUN_BIT];
            if (wr_tmatch) match_time_q <= cal_time_t'(wr_data);
            if (wr_ymatch) match_year_q <= wr_data[YEAR_W-1:0];
        end
    end

    cal_time_counter u_time (
        .clk        (clk),
        .rst        (rst),
        .advance    (advance),
        .load_en    (ld_time),
        .load_val   (cal_time_t'(wr_data)),
        .leap       (leap),
        .time_q     (time_q),
        .year_carry (year_carry)
    );

    cal_bcd_counter #(
        .DIGITS    (YEAR_DIGITS),
        .RESET_VAL (RESET_YEAR)
    ) u_year (
        .clk      (clk),
        .rst      (rst),
        .inc      (year_carry),
        .load_en  (ld_year),
        .load_val (wr_data[YEAR_W-1:0]),
        .value_q  (year_q)
    );

    cal_alarm_unit u_alarm (
        .clk        (clk),
        .rst        (rst),
        .time_now   (time_q),
        .year_now   (year_q),
        .time_match (match_time_q),
        .year_match (match_year_q),
        .clear      (wr_clr),
        .status_q   (alarm)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_TIME, OFS_TLOAD: rd_data = time_q;
            OFS_TMATCH:          rd_data = match_time_q;
            OFS_CTRL:            rd_data[RUN_BIT] = run_q;
            OFS_STAT:            rd_data[0] = alarm;
            OFS_YEAR, OFS_YLOAD: rd_data[YEAR_W-1:0] = year_q;
            OFS_YMATCH:          rd_data[YEAR_W-1:0] = match_year_q;
            default:             rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
    import cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              run,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] time_word,
    input logic [YEAR_W-1:0] year_word,
    input logic [WORD_W-1:0] match_word,
    input logic [YEAR_W-1:0] match_year,
    input logic              alarm
);

    logic ld_t, ld_y, clr;
    assign ld_t = wr_en && (wr_addr == OFS_TLOAD);
    assign ld_y = wr_en && (wr_addr == OFS_YLOAD);
    assign clr  = wr_en && (wr_addr == OFS_CLR) && wr_data[0];

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (time_word == WORD_W'(TIME_RESET) && !alarm)) // R1
        else $error("reset state");

    AST_LOAD_TIME: assert property (@(posedge clk) disable iff (rst)
        ld_t |=> (time_word == $past(wr_data))) // R2
        else $error("time load");

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ld_t && !(sec_tick && run)) |=> $stable(time_word)) // R3
        else $error("time moved without tick");

    AST_YEAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld_y && !(sec_tick && run)) |=> $stable(year_word)) // R8
        else $error("year moved without tick");

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (alarm && !clr) |=> alarm) // R9
        else $error("alarm dropped");

    AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> $past(time_word == match_word && year_word == match_year)) // R11
        else $error("alarm without match");

endmodule

bind cal_clock cal_clock_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .run        (run_q),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .time_word  (time_q),
    .year_word  (year_q),
    .match_word (match_time_q),
    .match_year (match_year_q),
    .alarm      (alarm)
);

// File: tb/cal_clock_bench.sv
`timescale 1ns/1ps
module cal_clock_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        alarm;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cal_clock u_cal_clock (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .alarm(alarm)
    );

    function automatic logic [31:0] mk(int mon, int mday, int wday, int hr, int mi, int s);
        return (32'(mon) << 25) | (32'(mday) << 20) | (32'(wday) << 17)
             | (32'(hr) << 12) | (32'(mi) << 6) | 32'(s);
    endfunction

    function automatic logic [31:0] to_bcd(int y);
        return 32'(((y / 1000) % 10) << 12 | ((y / 100) % 10) << 8
                 | ((y / 10) % 10) << 4 | (y % 10));
    endfunction

    function automatic int dim(int mon, int y);
        bit lp;
        lp = ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
        if (mon == 2) return lp ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); check("R1 time", v, 32'h0212_0000);
        rd(8'h30, v); check("R1 year", v, 32'h2000);
        rd(8'h0C, v); check("R1 ctrl", v, 32'h0);
        rd(8'h14, v); check("R1 status", v, 32'h0);
        check("R1 alarm", {31'd0, alarm}, 32'h0);

        // R3 stopped: ticks ignored; R2 loads work while stopped
        tick(); tick();
        rd(8'h00, v); check("R3 stopped time", v, 32'h0212_0000);
        wr(8'h08, mk(5, 6, 3, 7, 8, 9));
        wr(8'h38, 32'h1987);
        rd(8'h08, v); check("R2 time load", v, mk(5, 6, 3, 7, 8, 9));
        rd(8'h38, v); check("R2 year load", v, 32'h1987);
        tick();
        rd(8'h00, v); check("R3 stopped after load", v, mk(5, 6, 3, 7, 8, 9));

        // R12 control readback, enable run
        wr(8'h0C, 32'h0400_0000);
        rd(8'h0C, v); check("R12 ctrl readback", v, 32'h0400_0000);
        tick();
        rd(8'h00, v); check("R3 running", v, mk(5, 6, 3, 7, 8, 10));

        // R2 load beats tick in same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h08; wr_data = mk(1, 2, 3, 4, 5, 6); sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
        rd(8'h00, v); check("R2 load over tick", v, mk(1, 2, 3, 4, 5, 6));

        // R4 sweep: two hours across midnight
        begin
            int t;
            int bad;
            wr(8'h38, 32'h2023);
            wr(8'h08, mk(3, 10, 2, 22, 0, 0));
            t = 22 * 3600;
            bad = 0;
            for (int k = 0; k < 7200; k++) begin
                logic [31:0] e;
                tick();
                t++;
                if (t >= 86400) e = mk(3, 11, 3, (t - 86400) / 3600, ((t - 86400) / 60) % 60, (t - 86400) % 60);
                else            e = mk(3, 10, 2, t / 3600, (t / 60) % 60, t % 60);
                rd(8'h00, v);
                if (v !== e) bad++;
            end
            check("R4 sweep mismatches", 32'(bad), 32'd0);
            rd(8'h00, v); check("R4 end of sweep", v, mk(3, 11, 3, 0, 0, 0));
        end

        // R5 weekday wrap
        wr(8'h08, mk(6, 10, 7, 23, 59, 59)); tick();
        rd(8'h00, v); check("R5 wday 7->1", v, mk(6, 11, 1, 0, 0, 0));
        wr(8'h08, mk(6, 10, 3, 23, 59, 59)); tick();
        rd(8'h00, v); check("R5 wday 3->4", v, mk(6, 11, 4, 0, 0, 0));

        // R6/R7/R8 month-end sweep
        begin
            int yrs[2] = '{2023, 2024};
            foreach (yrs[j]) begin
                for (int m = 1; m <= 12; m++) begin
                    int d;
                    d = dim(m, yrs[j]);
                    wr(8'h38, to_bcd(yrs[j]));
                    wr(8'h08, mk(m, d - 1, 2, 23, 59, 59)); tick();
                    rd(8'h00, v); check("R6 day advance", v, mk(m, d, 3, 0, 0, 0));
                    wr(8'h08, mk(m, d, 2, 23, 59, 59)); tick();
                    rd(8'h00, v); check("R6 month end", v, mk(m == 12 ? 1 : m + 1, 1, 3, 0, 0, 0));
                    rd(8'h30, v); check("R8 year", v, to_bcd(m == 12 ? yrs[j] + 1 : yrs[j]));
                end
            end
        end
        begin
            int cy[4] = '{1900, 2000, 2100, 2400};
            foreach (cy[j]) begin
                int d;
                d = dim(2, cy[j]);
                wr(8'h38, to_bcd(cy[j]));
                wr(8'h08, mk(2, 28, 5, 23, 59, 59)); tick();
                rd(8'h00, v);
                check("R7 century Feb", v, (d == 29) ? mk(2, 29, 6, 0, 0, 0) : mk(3, 1, 6, 0, 0, 0));
            end
        end

        // R8 decimal carries
        wr(8'h38, 32'h1999); wr(8'h08, mk(12, 31, 4, 23, 59, 59)); tick();
        rd(8'h30, v); check("R8 1999->2000", v, 32'h2000);
        wr(8'h38, 32'h9999); wr(8'h08, mk(12, 31, 4, 23, 59, 59)); tick();
        rd(8'h30, v); check("R8 9999->0000", v, 32'h0000);
        rd(8'h00, v); check("R8 new year time", v, mk(1, 1, 5, 0, 0, 0));

        // R9 alarm
        wr(8'h38, 32'h2031);
        wr(8'h08, mk(7, 4, 6, 12, 30, 0));
        wr(8'h04, mk(7, 4, 6, 12, 30, 1));
        wr(8'h34, 32'h2031);
        rd(8'h04, v); check("R12 match readback", v, mk(7, 4, 6, 12, 30, 1));
        rd(8'h34, v); check("R12 year match readback", v, 32'h2031);
        check("R9 alarm before", {31'd0, alarm}, 32'h0);
        tick();
        check("R9 alarm latency", {31'd0, alarm}, 32'h0);
        @(negedge clk);
        check("R9 alarm set", {31'd0, alarm}, 32'h1);
        rd(8'h14, v); check("R9 status bit0", v, 32'h1);
        wr(8'h0C, 32'h0); // stop so equality persists
        repeat (3) @(negedge clk);
        check("R9 alarm sticky", {31'd0, alarm}, 32'h1);

        // R10 clear
        wr(8'h1C, 32'h1);
        check("R10 cleared", {31'd0, alarm}, 32'h0);
        repeat (3) @(negedge clk);
        check("R10 stays clear", {31'd0, alarm}, 32'h0);
        rd(8'h20, v); check("R12 unmapped", v, 32'h0);

        // R11 weekday participates
        wr(8'h0C, 32'h0400_0000);
        wr(8'h08, mk(7, 4, 6, 12, 31, 0));
        wr(8'h04, mk(7, 4, 2, 12, 31, 1));
        tick();
        repeat (3) @(negedge clk);
        check("R11 wday mismatch no alarm", {31'd0, alarm}, 32'h0);
        wr(8'h04, mk(7, 4, 6, 12, 31, 3));
        wr(8'h34, 32'h2032);
        tick(); tick();
        repeat (3) @(negedge clk);
        check("R9 year mismatch no alarm", {31'd0, alarm}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule